// File: doc/BRIEF.md
# Two-Channel Playback Command Sequencer

This block sits between a host byte stream and two sample playback engines. It decodes one-byte and two-byte commands from the host and keeps the control state of two independent voice channels: power state, the phrase each channel will play, an optional timed silence, a repeat (loop) flag and a volume code. It sends start and stop pulses with phrase numbers to the engines, and the engines report back when a phrase has ended. For each channel it drives two status lines: a ready line (the channel can take its next play, start or silence command) and an active-low busy line.

Command bytes arrive over a valid/ready stream. A side flag, `cmd_first`, marks a byte as an opcode; a byte without it is the operand of the two-byte command that is waiting. The block holds `cmd_ready` low while it works on a command, so the host must keep `cmd_valid`, `cmd_first` and `cmd_data` steady until a cycle with both valid and ready high. A byte is taken only in such a cycle. The engine side has no back-pressure: the pulses last one cycle and the phrase and volume outputs are plain registers.

Top module: `dual_voice_cmd_seq`

## Requirements
- R1: The opcode is `cmd_data[7:4]` and the channel mask is `cmd_data[1:0]`, with bit 0 for channel 1 and bit 1 for channel 2. Bits 3..2 must be zero, or the byte is dropped. The opcodes are: 0 power-up, 1 soft power-up, 2 power-down, 3 soft power-down, 4 play, 5 start, 6 phrase set, 7 stop, 8 silence, 9 loop clear, A loop set, B volume, D flash. A flash byte runs the processing window and changes no state. C, E and F are dropped without a processing window.
- R2: After reset the block is powered down. `ncr` reads 0, `busy_n` reads 3 and `cmd_ready` reads 1.
- R3: While the block is powered down, every opcode except 0 and 1 is dropped. An operand byte that arrives with no command waiting is ignored.
- R4: An accepted command holds `cmd_ready` low for PROC_CYC+1 cycles (SOFT_CYC+1 for opcodes 1 and 3). During that time `ncr` and `busy_n` both read 0. Power-up makes `ncr` read 3.
- R5: Play (4, then a phrase byte) starts every masked idle channel. It pulses `start_req` and sets that channel's `phrase_out` byte (channel 1 in bits 7:0).
- R6: Phrase set (6, then a phrase byte) stores the phrase of the masked channels and starts nothing. Start (5) starts the masked idle channels with their stored phrases.
- R7: Stop (7) pulses `stop_req` for each masked channel that is playing. It ends both playback and silence on the masked channels and clears their loop flag.
- R8: Silence (8, then M) keeps the masked idle channel active for (M+1)*4 ms, counted in ticks of CLK_PER_MS clocks. Meanwhile its `busy_n` is 0 and its `ncr` is 0.
- R9: Loop set (A) affects only a channel that is playing. When the engine reports the end of a phrase on a looping channel, the same phrase restarts. On a channel that is not looping, the channel goes idle.
- R10: Loop clear (9) removes the loop flag, so the next end of phrase makes the channel idle.
- R11: Volume (B, then a byte V) sets a 5-bit code of min(V,28) on each masked channel. Channel 1 is in `vol_out[4:0]`.
- R12: A new opcode byte that arrives while an operand is awaited cancels the waiting command and is decoded as a fresh command.
- R13: Play, start and silence are ignored on a channel that is already playing or silent. Its phrase and state are left unchanged.
- R14: Power-down stops both channels, pulsing `stop_req` for each one that is playing, and sets `ncr` to 0 until the next power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Host byte valid |
| cmd_first | input | 1 | Byte is an opcode (1) or an operand (0) |
| cmd_data | input | 8 | Host byte |
| cmd_ready | output | 1 | Block accepts a byte this cycle |
| eng_done | input | 2 | End-of-phrase pulse from each engine |
| start_req | output | 2 | Start pulse per channel |
| stop_req | output | 2 | Stop pulse per channel |
| phrase_out | output | 16 | Phrase number per channel, channel 1 in the low byte |
| vol_out | output | 10 | Volume code per channel, channel 1 in bits 4:0 |
| ncr | output | 2 | Channel ready for its next play, start or silence |
| busy_n | output | 2 | Low while the channel is active or a command is in progress |

## Verification
The bench goes after the cases where timing or state interact. One case is an end-of-phrase report on a looping channel. A design that drops the loop flag would go idle at that point, and one that fails to clear the flag on stop would replay the phrase after stopping. Other cases are a play sent to a channel that is already playing or silent, and an operand-waiting command cancelled by a new opcode. A design that queues or overwrites here would emit a stray start or change the phrase, and the scoreboard of start and stop events would catch it. The processing window is measured exactly in cycles for both the immediate and the soft power opcodes. Volume bytes at 29 and 255 show whether the code is clamped or truncated.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int NCH = 2;

  typedef enum logic [3:0] {
    OP_PUP   = 4'h0,
    OP_PUPS  = 4'h1,
    OP_PDN   = 4'h2,
    OP_PDNS  = 4'h3,
    OP_PLAY  = 4'h4,
    OP_START = 4'h5,
    OP_FADR  = 4'h6,
    OP_STOP  = 4'h7,
    OP_MUON  = 4'h8,
    OP_LCLR  = 4'h9,
    OP_LSET  = 4'hA,
    OP_VOL   = 4'hB,
    OP_EXT   = 4'hC,
    OP_FLASH = 4'hD,
    OP_RSVE  = 4'hE,
    OP_RSVF  = 4'hF
  } op_e;

  typedef struct packed {
    op_e            op;
    logic [NCH-1:0] mask;
    logic [7:0]     arg;
  } cmd_t;

  function automatic logic op_has_arg(op_e op);
    return (op == OP_PLAY) || (op == OP_FADR) || (op == OP_MUON) || (op == OP_VOL);
  endfunction

  function automatic logic op_known(op_e op);
    return !((op == OP_EXT) || (op == OP_RSVE) || (op == OP_RSVF));
  endfunction

  function automatic logic op_soft(op_e op);
    return (op == OP_PUPS) || (op == OP_PDNS);
  endfunction

  function automatic logic op_powerup(op_e op);
    return (op == OP_PUP) || (op == OP_PUPS);
  endfunction
endpackage

// File: rtl/vseq_decoder.sv
module vseq_decoder
  import vseq_pkg::*;
#(
  parameter int PROC_CYC = 4,
  parameter int SOFT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_first,
  input  logic [7:0] in_data,
  output logic in_ready,
  input  logic pwr_on,
  output logic exec_o,
  output cmd_t cmd_o,
  output logic proc_o
);
  localparam int MAXC = (SOFT_CYC > PROC_CYC) ? SOFT_CYC : PROC_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_OPND, S_PROC} st_e;

  st_e           st;
  logic [CW-1:0] cnt;
  cmd_t          hold;
  logic          exec_q;
  op_e           new_op;
  logic          admit;
  logic          take;

  assign new_op   = op_e'(in_data[7:4]);
  assign admit    = op_known(new_op) && (in_data[3:2] == 2'b00) &&
                    (pwr_on || op_powerup(new_op));
  assign in_ready = (st != S_PROC) && !exec_q;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      hold   <= '0;
      exec_q <= 1'b0;
    end else begin
      exec_q <= 1'b0;
      case (st)
        S_IDLE, S_OPND: begin
          if (take && in_first) begin
            if (admit) begin
              hold.op   <= new_op;
              hold.mask <= in_data[1:0];
              hold.arg  <= 8'h00;
              if (op_has_arg(new_op)) begin
                st <= S_OPND;
              end else begin
                st  <= S_PROC;
                cnt <= op_soft(new_op) ? CW'(SOFT_CYC - 1) : CW'(PROC_CYC - 1);
              end
            end else begin
              st <= S_IDLE;
            end
          end else if (take && (st == S_OPND)) begin
            hold.arg <= in_data;
            st       <= S_PROC;
            cnt      <= CW'(PROC_CYC - 1);
          end
        end
        default: begin
          if (cnt == '0) begin
            st     <= S_IDLE;
            exec_q <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign exec_o = exec_q;
  assign cmd_o  = hold;
  assign proc_o = (st == S_PROC) || exec_q;
endmodule

// File: rtl/vseq_tick.sv
module vseq_tick #(
  parameter int DIV = 4096
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == W'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/vseq_chan.sv
module vseq_chan
  import vseq_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int VOL_MAX = 28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  cmd_t       cmd,
  input  logic       ms_tick,
  input  logic       eng_done,
  output logic       start_o,
  output logic       stop_o,
  output logic [7:0] phrase_o,
  output logic [4:0] vol_o,
  output logic       play_o,
  output logic       sil_o,
  output logic       loop_o
);
  localparam int SW = 11;

  logic [SW-1:0] sil_q;
  logic          play_q;
  logic          loop_q;
  logic          active;
  logic          hit;
  logic          pdown;

  assign active = play_q || (sil_q != '0);
  assign hit    = exec && cmd.mask[IDX];
  assign pdown  = exec && ((cmd.op == OP_PDN) || (cmd.op == OP_PDNS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sil_q    <= '0;
      play_q   <= 1'b0;
      loop_q   <= 1'b0;
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
      phrase_o <= 8'h00;
      vol_o    <= 5'd0;
    end else begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      if (play_q && eng_done) begin
        if (loop_q) start_o <= 1'b1;
        else        play_q  <= 1'b0;
      end
      if ((sil_q != '0) && ms_tick) sil_q <= sil_q - 1'b1;
      if (pdown) begin
        stop_o  <= play_q;
        start_o <= 1'b0;
        play_q  <= 1'b0;
        loop_q  <= 1'b0;
        sil_q   <= '0;
      end else if (hit) begin
        case (cmd.op)
          OP_PLAY: if (!active) begin
            phrase_o <= cmd.arg;
            play_q   <= 1'b1;
            start_o  <= 1'b1;
          end
          OP_START: if (!active) begin
            play_q  <= 1'b1;
            start_o <= 1'b1;
          end
          OP_FADR: phrase_o <= cmd.arg;
          OP_STOP: begin
            stop_o  <= play_q;
            start_o <= 1'b0;
            play_q  <= 1'b0;
            loop_q  <= 1'b0;
            sil_q   <= '0;
          end
          OP_MUON: if (!active) sil_q <= {({1'b0, cmd.arg} + 9'd1), 2'b00};
          OP_LSET: if (play_q && !eng_done) loop_q <= 1'b1;
          OP_LCLR: loop_q <= 1'b0;
          OP_VOL:  vol_o <= (cmd.arg > 8'(VOL_MAX)) ? 5'(VOL_MAX) : cmd.arg[4:0];
          default: ;
        endcase
      end
    end
  end

  assign play_o = play_q;
  assign sil_o  = (sil_q != '0);
  assign loop_o = loop_q;
endmodule

// File: rtl/dual_voice_cmd_seq.sv
module dual_voice_cmd_seq
  import vseq_pkg::*;
#(
  parameter int CLK_PER_MS = 4096,
  parameter int PROC_CYC   = 4,
  parameter int SOFT_CYC   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_first,
  input  logic [7:0]  cmd_data,
  output logic        cmd_ready,
  input  logic [1:0]  eng_done,
  output logic [1:0]  start_req,
  output logic [1:0]  stop_req,
  output logic [15:0] phrase_out,
  output logic [9:0]  vol_out,
  output logic [1:0]  ncr,
  output logic [1:0]  busy_n
);
  logic           exec;
  logic           proc;
  cmd_t           cmd;
  logic           ms_tick;
  logic           pwr_on;
  logic [NCH-1:0] play_v;
  logic [NCH-1:0] sil_v;
  logic [NCH-1:0] loop_v;

  vseq_decoder #(.PROC_CYC(PROC_CYC), .SOFT_CYC(SOFT_CYC)) u_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(cmd_valid), .in_first(cmd_first),
    .in_data(cmd_data), .in_ready(cmd_ready), .pwr_on(pwr_on),
    .exec_o(exec), .cmd_o(cmd), .proc_o(proc)
  );

  vseq_tick #(.DIV(CLK_PER_MS)) u_tick (.clk(clk), .rst_n(rst_n), .tick(ms_tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_on <= 1'b0;
    end else if (exec) begin
      if (op_powerup(cmd.op)) pwr_on <= 1'b1;
      else if ((cmd.op == OP_PDN) || (cmd.op == OP_PDNS)) pwr_on <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    vseq_chan #(.IDX(g)) u_ch (
      .clk(clk), .rst_n(rst_n), .exec(exec), .cmd(cmd), .ms_tick(ms_tick),
      .eng_done(eng_done[g]), .start_o(start_req[g]), .stop_o(stop_req[g]),
      .phrase_o(phrase_out[g*8 +: 8]), .vol_o(vol_out[g*5 +: 5]),
      .play_o(play_v[g]), .sil_o(sil_v[g]), .loop_o(loop_v[g])
    );
    assign busy_n[g] = !proc && !play_v[g] && !sil_v[g];
    assign ncr[g]    = pwr_on && busy_n[g];
  end
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic [1:0] ncr,
  input logic [1:0] start_req,
  input logic [1:0] stop_req,
  input logic [9:0] vol_out,
  input logic       pwr_on,
  input logic [1:0] play_v,
  input logic [1:0] loop_v
);
  // R4
  ready_when_ncr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ncr != 2'b00) |-> cmd_ready);

  // R7
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req & stop_req) == 2'b00);

  // R14
  pd_no_ncr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (ncr == 2'b00));

  // R11
  vol_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_out[4:0] <= 5'd28) && (vol_out[9:5] <= 5'd28));

  // R9
  loop_needs_play_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_v & ~play_v) == 2'b00);

  // R3
  start_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req != 2'b00) |-> pwr_on);
endmodule

bind dual_voice_cmd_seq vseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .ncr(ncr),
  .start_req(start_req), .stop_req(stop_req), .vol_out(vol_out),
  .pwr_on(pwr_on), .play_v(play_v), .loop_v(loop_v)
);

// File: tb/tb_dual_voice_cmd_seq.sv
module tb_dual_voice_cmd_seq;
  localparam int PROC = 4;
  localparam int SOFT = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_first = 1'b0;
  logic [7:0]  cmd_data = 8'h00;
  logic        cmd_ready;
  logic [1:0]  eng_done = 2'b00;
  logic [1:0]  start_req, stop_req, ncr, busy_n;
  logic [15:0] phrase_out;
  logic [9:0]  vol_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct packed {
    logic [3:0] req;
    logic       is_stop;
    logic       ch;
    logic [7:0] ph;
  } ev_t;
  ev_t expq[$];

  dual_voice_cmd_seq #(.CLK_PER_MS(4), .PROC_CYC(PROC), .SOFT_CYC(SOFT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_first(cmd_first),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready), .eng_done(eng_done),
    .start_req(start_req), .stop_req(stop_req), .phrase_out(phrase_out),
    .vol_out(vol_out), .ncr(ncr), .busy_n(busy_n)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int req, input bit is_stop, input bit ch, input logic [7:0] ph);
    expq.push_back('{req: 4'(req), is_stop: is_stop, ch: ch, ph: ph});
  endtask

  // monitor: compare engine-side pulses against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 2; k++) begin
          if ((k == 0 && start_req[c]) || (k == 1 && stop_req[c])) begin
            if (expq.size() == 0) begin
              chk(0, k ? "R7 unexpected stop" : "R13 unexpected start", c, -1);
            end else begin
              ev_t e;
              e = expq.pop_front();
              n_chk++;
              if (e.is_stop != k[0] || e.ch != c[0] ||
                  (k == 0 && phrase_out[c*8 +: 8] != e.ph)) begin
                n_fail++;
                $display("FAIL R%0d event actual=stop%0d/ch%0d/ph%0h expected=stop%0d/ch%0d/ph%0h",
                         e.req, k, c, phrase_out[c*8 +: 8], e.is_stop, e.ch, e.ph);
              end
            end
          end
        end
      end
    end
  end

  task automatic put(input logic f, input logic [7:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_first = f; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_first = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!cmd_ready) begin n++; @(negedge clk); end
  endtask

  task automatic op1(input logic [7:0] d);
    int n;
    put(1'b1, d); wait_ready(n);
  endtask

  task automatic op2(input logic [7:0] d, input logic [7:0] a);
    int n;
    put(1'b1, d); put(1'b0, a); wait_ready(n);
  endtask

  task automatic done_pulse(input logic [1:0] m);
    @(negedge clk); eng_done = m;
    @(negedge clk); eng_done = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(ncr == 2'b00, "R2 ncr", ncr, 0);
    chk(busy_n == 2'b11, "R2 busy_n", busy_n, 3);
    chk(cmd_ready, "R2 ready", cmd_ready, 1);

    // R3 play while powered down, stray operand
    put(1'b1, 8'h41); put(1'b0, 8'h05);
    repeat (10) @(negedge clk);
    chk(ncr == 2'b00, "R3 still down", ncr, 0);
    chk(phrase_out == 16'h0000, "R3 phrase untouched", phrase_out, 0);

    // R4 immediate power-up window
    put(1'b1, 8'h00);
    chk(ncr == 2'b00 && busy_n == 2'b00, "R4 status low in window", {ncr, busy_n}, 0);
    wait_ready(n);
    chk(n == PROC + 1, "R4 window length", n, PROC + 1);
    chk(ncr == 2'b11 && busy_n == 2'b11, "R4 ready after power-up", {ncr, busy_n}, 15);
    // R4 soft power-down then soft power-up
    put(1'b1, 8'h30); wait_ready(n);
    chk(n == SOFT + 1, "R4 soft down window", n, SOFT + 1);
    chk(ncr == 2'b00, "R4 down ncr", ncr, 0);
    put(1'b1, 8'h10); wait_ready(n);
    chk(n == SOFT + 1, "R4 soft up window", n, SOFT + 1);
    chk(ncr == 2'b11, "R4 up ncr", ncr, 3);

    // R1 reserved bits set: dropped
    put(1'b1, 8'h24);
    chk(cmd_ready, "R1 no window on bad byte", cmd_ready, 1);
    chk(ncr == 2'b11, "R1 still powered", ncr, 3);
    // R1 unknown opcode dropped, flash opcode processed
    put(1'b1, 8'hE1);
    chk(cmd_ready, "R1 unknown dropped", cmd_ready, 1);
    put(1'b1, 8'hD0);
    chk(!cmd_ready, "R1 flash runs window", cmd_ready, 0);
    wait_ready(n);

    // R5 play channel 1
    expect_ev(5, 0, 0, 8'h2A);
    op2(8'h41, 8'h2A);
    chk(busy_n == 2'b10 && ncr == 2'b10, "R5 ch1 busy", {ncr, busy_n}, 10);
    chk(phrase_out[7:0] == 8'h2A, "R5 phrase", phrase_out[7:0], 8'h2A);

    // R13 play both: ch1 busy ignored, ch2 starts
    expect_ev(13, 0, 1, 8'h11);
    op2(8'h43, 8'h11);
    chk(phrase_out == 16'h112A, "R13 phrase kept on busy ch", phrase_out, 16'h112A);

    // R9 loop on playing ch1 restarts
    op1(8'hA1);
    expect_ev(9, 0, 0, 8'h2A);
    done_pulse(2'b01);
    chk(busy_n[0] == 1'b0, "R9 looping stays busy", busy_n[0], 0);
    // R10 clear loop, then end goes idle
    op1(8'h91);
    done_pulse(2'b01);
    chk(busy_n[0] == 1'b1, "R10 idle after clear", busy_n[0], 1);
    // R9 loop set on idle channel has no effect
    op1(8'hA1);
    expect_ev(9, 0, 0, 8'h07);
    op2(8'h41, 8'h07);
    done_pulse(2'b01);
    chk(busy_n[0] == 1'b1, "R9 idle loop ignored", busy_n[0], 1);

    // R7 stop clears loop
    op1(8'hA2);
    expect_ev(7, 1, 1, 8'h00);
    op1(8'h72);
    chk(busy_n[1] == 1'b1, "R7 stopped", busy_n[1], 1);
    expect_ev(7, 0, 1, 8'h33);
    op2(8'h42, 8'h33);
    done_pulse(2'b10);
    chk(busy_n[1] == 1'b1, "R7 loop cleared by stop", busy_n[1], 1);

    // R6 phrase set then start both
    op2(8'h63, 8'h44);
    chk(phrase_out == 16'h4444 && busy_n == 2'b11, "R6 set without start", phrase_out, 16'h4444);
    expect_ev(6, 0, 0, 8'h44);
    expect_ev(6, 0, 1, 8'h44);
    op1(8'h53);
    chk(busy_n == 2'b00, "R6 both playing", busy_n, 0);
    done_pulse(2'b11);
    chk(busy_n == 2'b11, "R6 both idle", busy_n, 3);

    // R8 silence of 3 units of 4 ms on ch1
    op2(8'h81, 8'h02);
    chk(busy_n == 2'b10 && ncr == 2'b10, "R8 silence active", {ncr, busy_n}, 10);
    op2(8'h41, 8'h09);   // R13 ignored during silence
    chk(busy_n[0] == 1'b0, "R8 still silent", busy_n[0], 0);
    chk(phrase_out[7:0] == 8'h44, "R13 play ignored in silence", phrase_out[7:0], 8'h44);
    repeat (45) @(negedge clk);
    chk(busy_n[0] == 1'b1 && ncr[0] == 1'b1, "R8 silence over", {ncr[0], busy_n[0]}, 3);

    // R11 volume and clamp
    op2(8'hB1, 8'h0A);
    chk(vol_out[4:0] == 5'd10, "R11 vol ch1", vol_out[4:0], 10);
    op2(8'hB2, 8'hFF);
    chk(vol_out[9:5] == 5'd28, "R11 clamp 255", vol_out[9:5], 28);
    op2(8'hB1, 8'h1D);
    chk(vol_out[4:0] == 5'd28, "R11 clamp 29", vol_out[4:0], 28);

    // R12 pending play aborted by a volume opcode
    put(1'b1, 8'h41); put(1'b1, 8'hB1); put(1'b0, 8'h05); wait_ready(n);
    chk(vol_out[4:0] == 5'd5, "R12 fresh decode", vol_out[4:0], 5);
    chk(busy_n[0] == 1'b1, "R12 no start", busy_n[0], 1);

    // R14 power-down stops both
    expect_ev(14, 0, 0, 8'h01);
    expect_ev(14, 0, 1, 8'h01);
    op2(8'h43, 8'h01);
    expect_ev(14, 1, 0, 8'h00);
    expect_ev(14, 1, 1, 8'h00);
    op1(8'h20);
    chk(ncr == 2'b00 && busy_n == 2'b11, "R14 down state", {ncr, busy_n}, 3);
    put(1'b1, 8'h41); put(1'b0, 8'h02);
    repeat (10) @(negedge clk);
    chk(ncr == 2'b00 && busy_n == 2'b11, "R14 play ignored", {ncr, busy_n}, 3);

    chk(expq.size() == 0, "R5 events outstanding", expq.size(), 0);
    finish_run();
  end
endmodule